// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt and DMA Status Register

This block holds the interrupt and bus-master status state of a two-channel IDE host controller. Each channel has a drive interrupt line. A rising edge on that line latches a pending flag. A shared mode register lets software enable delivery to the host and acknowledge either channel's flag. The block drives a single host interrupt, which is the OR of the two flags gated by the enable.

Each channel also has a DMA command register and a DMA status register. Writing the start bit of the command register marks the channel's transfer active, and clearing it drops the active state. The status register shows the active bit, an error bit latched from the channel's DMA error input, and an interrupt bit that mirrors the channel's pending flag. The error and interrupt bits clear when software writes 1 to them. A per-channel output reports when the channel's transfer ended cleanly.

Software reaches the registers through a byte-wide port. It gives a write strobe, a register select and a channel select, and reads back combinationally.

Top module: `ide_irq_status`

## Requirements
- R1: After reset every register reads 0x00 for both channels, `host_irq` is low and `xfer_ok` is 0.
- R2: A 0-to-1 change on `drv_irq[c]`, seen at a clock edge, sets channel c's pending flag at that edge. A line that stays high does not set the flag again after it has been cleared.
- R3: Writing the mode register (select 0) with bit 2 set clears channel 0's pending flag, and bit 3 set clears channel 1's. A 0 in either bit leaves that flag as it was, so acknowledging one channel never disturbs the other.
- R4: Reading the mode register returns channel 0's pending flag in bit 2 and channel 1's in bit 3. Bits 1:0 (write-only controls) and bits 7:4 always read 0.
- R5: Mode bit 1 is the interrupt enable. It is stored on every mode write. `host_irq` is high exactly when the enable is set and at least one pending flag is set.
- R6: When a clear of a pending flag and a new rising edge on the same channel fall in the same cycle, the flag stays set.
- R7: The status register (select 2, channel from `chan_sel`) shows the pending flag in bit 2. Writing 1 to status bit 2 clears that channel's pending flag, and the mode register then also reads it cleared.
- R8: A high `dma_err[c]` at a clock edge sets status bit 1 of channel c. Writing 1 to that bit clears it. If the error input is high in the same cycle as the clear, the bit stays set.
- R9: The command register (select 1) stores only bit 0 (start) and bit 3 (direction); its other bits read 0. Status bit 0 follows the stored start bit: it goes to 1 when 1 is written to command bit 0 and to 0 when 0 is written. A write to status bit 0 has no effect.
- R10: `xfer_ok[c]` is high exactly when channel c's status bits 2:0 equal 3'b100 (interrupt set, no error, not active). Select 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_irq | input | 2 | Drive interrupt line per channel |
| dma_err | input | 2 | DMA error event per channel |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 mode, 1 command, 2 status, 3 unused |
| chan_sel | input | 1 | Channel for command and status access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| host_irq | output | 1 | Combined host interrupt |
| xfer_ok | output | 2 | Clean transfer completion per channel |

## Verification
The hardest cases to reach from the ports are collisions in a single cycle: an acknowledge write that lands on the same edge as a new drive edge or a new error event. A second hard case is an acknowledge through one register that must show up in the other. Directed sequences first drop the drive line for a cycle, then raise it together with the clearing write. Random traffic then mixes line toggles, error pulses and writes to all selects. A bench model predicts every readback, `host_irq` and `xfer_ok`.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // mode register layout
  localparam int MODE_EN_BIT   = 1;
  localparam int MODE_PEND_LSB = 2;

  // status register layout
  localparam int STAT_ACT_BIT = 0;
  localparam int STAT_ERR_BIT = 1;
  localparam int STAT_IRQ_BIT = 2;

  // command register layout
  localparam int CMD_START_BIT = 0;
  localparam int CMD_DIR_BIT   = 3;

endpackage

// File: rtl/ide_irq_edge.sv
module ide_irq_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);

  logic [N-1:0] prev_q;
  logic [N-1:0] prev_d;

  always_comb begin
    prev_d = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign rise = lvl & ~prev_q;

endmodule

// File: rtl/ide_irq_mode.sv
module ide_irq_mode
  import ide_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic          en
);

  logic en_q;
  logic en_d;

  always_comb begin
    en_d = en_q;
    if (we) begin
      en_d = wdata[MODE_EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

  assign en = en_q;

endmodule

// File: rtl/ide_irq_chan.sv
module ide_irq_chan
  import ide_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic          err_set,
  input  logic          pend_clr,
  input  logic          err_clr,
  input  logic          cmd_we,
  input  logic [DW-1:0] cmd_wdata,
  output logic          pend,
  output logic          err,
  output logic [DW-1:0] cmd
);

  localparam logic [DW-1:0] CMD_MASK =
    (DW'(1) << CMD_START_BIT) | (DW'(1) << CMD_DIR_BIT);

  logic          pend_q, pend_d;
  logic          err_q, err_d;
  logic [DW-1:0] cmd_q, cmd_d;

  always_comb begin
    // a new event wins over a same-cycle clear
    pend_d = rise | (pend_q & ~pend_clr);
    err_d  = err_set | (err_q & ~err_clr);
    cmd_d  = cmd_q;
    if (cmd_we) begin
      cmd_d = cmd_wdata & CMD_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      err_q  <= 1'b0;
      cmd_q  <= '0;
    end else begin
      pend_q <= pend_d;
      err_q  <= err_d;
      cmd_q  <= cmd_d;
    end
  end

  assign pend = pend_q;
  assign err  = err_q;
  assign cmd  = cmd_q;

endmodule

// File: rtl/ide_irq_status.sv
module ide_irq_status
  import ide_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    drv_irq,
  input  logic [1:0]    dma_err,
  input  logic          wr_en,
  input  logic [1:0]    reg_sel,
  input  logic          chan_sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          host_irq,
  output logic [1:0]    xfer_ok
);

  localparam int NCH = 2;

  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_sel);

  logic            mode_we;
  logic            irq_en;
  logic [NCH-1:0]  rise_vec;
  logic [NCH-1:0]  pend_vec;
  logic [NCH-1:0]  err_vec;
  logic [NCH-1:0]  act_vec;
  logic [DW-1:0]   cmd_arr  [NCH];
  logic [DW-1:0]   stat_arr [NCH];

  assign mode_we = wr_en && (sel == SEL_MODE);

  ide_irq_edge #(.N(NCH)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (drv_irq),
    .rise (rise_vec)
  );

  ide_irq_mode #(.DW(DW)) u_mode (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (mode_we),
    .wdata(wdata),
    .en   (irq_en)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    logic stat_we;
    logic cmd_we;
    logic pend_clr;
    logic err_clr;

    assign hit      = (chan_sel == 1'(c));
    assign stat_we  = wr_en && (sel == SEL_STAT) && hit;
    assign cmd_we   = wr_en && (sel == SEL_CMD) && hit;
    assign pend_clr = (mode_we && wdata[MODE_PEND_LSB + c]) ||
                      (stat_we && wdata[STAT_IRQ_BIT]);
    assign err_clr  = stat_we && wdata[STAT_ERR_BIT];

    ide_irq_chan #(.DW(DW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise     (rise_vec[c]),
      .err_set  (dma_err[c]),
      .pend_clr (pend_clr),
      .err_clr  (err_clr),
      .cmd_we   (cmd_we),
      .cmd_wdata(wdata),
      .pend     (pend_vec[c]),
      .err      (err_vec[c]),
      .cmd      (cmd_arr[c])
    );

    assign act_vec[c] = cmd_arr[c][CMD_START_BIT];

    always_comb begin
      stat_arr[c] = '0;
      stat_arr[c][STAT_ACT_BIT] = act_vec[c];
      stat_arr[c][STAT_ERR_BIT] = err_vec[c];
      stat_arr[c][STAT_IRQ_BIT] = pend_vec[c];
    end

    assign xfer_ok[c] = pend_vec[c] && !err_vec[c] && !act_vec[c];
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_MODE: rdata[MODE_PEND_LSB +: NCH] = pend_vec;
      SEL_CMD:  rdata = cmd_arr[chan_sel];
      SEL_STAT: rdata = stat_arr[chan_sel];
      default:  rdata = '0;
    endcase
  end

  assign host_irq = irq_en && (|pend_vec);

endmodule

// File: rtl/ide_irq_status_chk.sv
module ide_irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] drv_irq,
  input logic       wr_en,
  input logic [1:0] reg_sel,
  input logic       chan_sel,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       host_irq,
  input logic [1:0] xfer_ok,
  input logic [1:0] pend,
  input logic [1:0] act,
  input logic       en
);

  logic [1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 2'b00;
    end else begin
      seen_q <= drv_irq;
    end
  end

  assert_mode_wo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd0) |-> (rdata[1:0] == 2'b00 && rdata[7:4] == 4'h0));

  assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !host_irq);

  for (genvar c = 0; c < 2; c++) begin : g_chk
    assert_pend_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_irq[c] && !seen_q[c]) |=> pend[c]);

    assert_pend_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == 2'd0 && wdata[2 + c] && !(drv_irq[c] && !seen_q[c]))
      |=> !pend[c]);

    assert_pend_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[c] && wr_en && reg_sel == 2'd0 && !wdata[2 + c]) |=> pend[c]);

    assert_cmd_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == 2'd1 && chan_sel == 1'(c) && !wdata[0]) |=> !act[c]);

    assert_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel == 2'd2 && chan_sel == 1'(c)) |-> (xfer_ok[c] == (rdata[2:0] == 3'b100)));
  end

endmodule

bind ide_irq_status ide_irq_status_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .drv_irq (drv_irq),
  .wr_en   (wr_en),
  .reg_sel (reg_sel),
  .chan_sel(chan_sel),
  .wdata   (wdata),
  .rdata   (rdata),
  .host_irq(host_irq),
  .xfer_ok (xfer_ok),
  .pend    (pend_vec),
  .act     (act_vec),
  .en      (irq_en)
);

// File: tb/ide_irq_status_tb.sv
module ide_irq_status_tb;

  logic       clk;
  logic       rst_n;
  logic [1:0] drv_irq;
  logic [1:0] dma_err;
  logic       wr_en;
  logic [1:0] reg_sel;
  logic       chan_sel;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       host_irq;
  logic [1:0] xfer_ok;

  int checks;
  int errors;
  bit done;

  // reference model state
  logic [1:0] m_pend, m_err, m_prev;
  logic [7:0] m_cmd [2];
  logic       m_en;

  ide_irq_status u_dut (
    .clk(clk), .rst_n(rst_n), .drv_irq(drv_irq), .dma_err(dma_err),
    .wr_en(wr_en), .reg_sel(reg_sel), .chan_sel(chan_sel), .wdata(wdata),
    .rdata(rdata), .host_irq(host_irq), .xfer_ok(xfer_ok)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] exp_read(logic [1:0] s, logic ch);
    logic [7:0] v;
    v = 8'h00;
    case (s)
      2'd0: v = {4'h0, m_pend, 2'b00};
      2'd1: v = m_cmd[ch];
      2'd2: v = {5'b0, m_pend[ch], m_err[ch], m_cmd[ch][0]};
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  function automatic logic exp_ok(int c);
    return m_pend[c] && !m_err[c] && !m_cmd[c][0];
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] irq, logic [1:0] er, logic w,
                       logic [1:0] s, logic ch, logic [7:0] d);
    @(negedge clk);
    drv_irq = irq; dma_err = er; wr_en = w; reg_sel = s; chan_sel = ch; wdata = d;
  endtask

  // advance one clock with the driven inputs, update model, compare outputs
  task automatic step(string tag);
    logic [1:0] rise, n_pend, n_err;
    logic [7:0] n_cmd [2];
    logic       n_en;
    rise = drv_irq & ~m_prev;
    n_en = m_en;
    if (wr_en && reg_sel == 2'd0) n_en = wdata[1];
    for (int c = 0; c < 2; c++) begin
      logic pc, ec;
      pc = (wr_en && reg_sel == 2'd0 && wdata[2 + c]) ||
           (wr_en && reg_sel == 2'd2 && chan_sel == 1'(c) && wdata[2]);
      ec = wr_en && reg_sel == 2'd2 && chan_sel == 1'(c) && wdata[1];
      n_pend[c] = rise[c] | (m_pend[c] & ~pc);
      n_err[c]  = dma_err[c] | (m_err[c] & ~ec);
      n_cmd[c]  = m_cmd[c];
      if (wr_en && reg_sel == 2'd1 && chan_sel == 1'(c)) n_cmd[c] = wdata & 8'h09;
    end
    @(posedge clk);
    #1;
    m_pend = n_pend; m_err = n_err; m_en = n_en; m_prev = drv_irq;
    m_cmd[0] = n_cmd[0]; m_cmd[1] = n_cmd[1];
    check(tag, rdata, exp_read(reg_sel, chan_sel));
    check({tag, " host_irq R5"}, {7'b0, host_irq}, {7'b0, m_en && (|m_pend)});
    check({tag, " xfer_ok R10"}, {6'b0, xfer_ok}, {6'b0, exp_ok(1), exp_ok(0)});
  endtask

  // look at one register without clocking
  task automatic peek(string tag, logic [1:0] s, logic ch, logic [7:0] exp);
    @(negedge clk);
    wr_en = 1'b0; reg_sel = s; chan_sel = ch;
    #1;
    check(tag, rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0;
    drv_irq = 2'b00; dma_err = 2'b00; wr_en = 1'b0; reg_sel = 2'd0; chan_sel = 1'b0; wdata = 8'h00;
    m_pend = 2'b00; m_err = 2'b00; m_prev = 2'b00; m_en = 1'b0;
    m_cmd[0] = 8'h00; m_cmd[1] = 8'h00;
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of every register
    for (int s = 0; s < 4; s++) begin
      for (int ch = 0; ch < 2; ch++) begin
        peek("R1 reset read", 2'(s), 1'(ch), 8'h00);
      end
    end
    check("R1 reset host_irq", {7'b0, host_irq}, 8'h00);
    check("R1 reset xfer_ok", {6'b0, xfer_ok}, 8'h00);

    // R2: rising edge on channel 0 latches its flag
    drive(2'b01, 2'b00, 1'b0, 2'd0, 1'b0, 8'h00); step("R2 edge ch0");
    peek("R2 mode shows ch0", 2'd0, 1'b0, 8'h04);
    // R5: enable off keeps host_irq low, then enable
    check("R5 disabled", {7'b0, host_irq}, 8'h00);
    drive(2'b01, 2'b00, 1'b1, 2'd0, 1'b0, 8'h02); step("R5 enable write");
    check("R5 enabled irq", {7'b0, host_irq}, 8'h01);
    // R4: write-only bits read 0
    peek("R4 mode readback", 2'd0, 1'b0, 8'h04);

    // R3: ch1 edge, then acknowledge only ch0
    drive(2'b11, 2'b00, 1'b0, 2'd0, 1'b0, 8'h00); step("R2 edge ch1");
    drive(2'b11, 2'b00, 1'b1, 2'd0, 1'b0, 8'h06); step("R3 clear ch0 only");
    peek("R3 ch1 kept", 2'd0, 1'b0, 8'h08);
    // R2: held-high line does not set again
    drive(2'b11, 2'b00, 1'b0, 2'd3, 1'b0, 8'h00); step("R2 no re-set while high");
    peek("R2 ch0 stays clear", 2'd0, 1'b0, 8'h08);

    // R6: clear collides with a new edge on ch0
    drive(2'b10, 2'b00, 1'b0, 2'd0, 1'b0, 8'h00); step("R6 drop line");
    drive(2'b11, 2'b00, 1'b1, 2'd0, 1'b0, 8'h06); step("R6 edge with clear");
    peek("R6 ch0 stays set", 2'd0, 1'b0, 8'h0C);

    // R7: status bit 2 mirror and clear through status
    peek("R7 status ch1 irq", 2'd2, 1'b1, 8'h04);
    drive(2'b11, 2'b00, 1'b1, 2'd2, 1'b1, 8'h04); step("R7 status clear ch1");
    peek("R7 mode sees ch1 clear", 2'd0, 1'b0, 8'h04);

    // R8: error latch, collision, clear
    drive(2'b11, 2'b10, 1'b0, 2'd2, 1'b1, 8'h00); step("R8 error set");
    drive(2'b11, 2'b10, 1'b1, 2'd2, 1'b1, 8'h02); step("R8 set wins over clear");
    peek("R8 err kept", 2'd2, 1'b1, 8'h02);
    drive(2'b11, 2'b00, 1'b1, 2'd2, 1'b1, 8'h02); step("R8 error clear");
    peek("R8 err gone", 2'd2, 1'b1, 8'h00);

    // R9: command mask, active follow, status bit 0 ignored
    drive(2'b11, 2'b00, 1'b1, 2'd1, 1'b0, 8'hFF); step("R9 cmd write");
    peek("R9 cmd mask", 2'd1, 1'b0, 8'h09);
    peek("R9 active set", 2'd2, 1'b0, 8'h05);
    check("R10 not ok while active", {6'b0, xfer_ok}, 8'h00);
    drive(2'b11, 2'b00, 1'b1, 2'd2, 1'b0, 8'h01); step("R9 status bit0 ignored");
    peek("R9 active kept", 2'd2, 1'b0, 8'h05);
    drive(2'b11, 2'b00, 1'b1, 2'd1, 1'b0, 8'h08); step("R9 stop");
    peek("R9 active dropped", 2'd2, 1'b0, 8'h04);
    check("R10 clean done ch0", {6'b0, xfer_ok}, 8'h01);

    // random traffic against the model (R2 R3 R5 R6 R7 R8 R9 R10)
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      logic [7:0]  d;
      r = $urandom;
      d = 8'($urandom);
      drive(r[1:0], (r[7:4] == 4'h0) ? r[9:8] : 2'b00, r[10], r[12:11], r[13], d);
      step("R2/R3/R7/R8/R9 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule